// File: doc/BRIEF.md
# Address Translation Front End

This block sits in front of a page-table walker and decides, for each memory access, what happens to its virtual address. It holds the 64-bit address-translation control register. It legalizes writes to that register. From the register and the effective privilege of the access, it works out which translation scheme applies. The possible schemes are no translation, a two-level 32-bit scheme, a three-level 39-bit scheme and a four-level 48-bit scheme.

Each access gets exactly one of three outcomes, decided in the same cycle:

- **Bypass.** The physical address is the virtual address.
- **Walk request.** The block passes to the walker the scheme, the 16-bit address-space identifier, the root table base, and the make-executable-readable and supervisor-user-access flags.
- **Immediate fault.** The virtual address is not canonical for the scheme. The fault carries the page-fault cause code that matches the access kind.

A narrow-supervisor input selects the 32-bit layout of the control register. Software uses it when the supervisor runs with a 32-bit register width.

Top module: `xlate_front`

## Requirements
- R1: After reset the control register reads zero, so every access, at any privilege, bypasses translation.
- R2: An access with effective privilege machine (priv = 3) always bypasses, and pa equals va, whatever the control register holds.
- R3: In the wide layout (narrow_sv = 0), bits 63:60 select the scheme: 0 selects no translation, 8 selects the 39-bit scheme and 9 selects the 48-bit scheme.
- R4: Under the 39-bit scheme, a va whose bits 63:38 are not all equal faults at once, and any other va issues a walk request.
- R5: Under the 48-bit scheme, a va whose bits 63:47 are not all equal faults at once, and any other va issues a walk request.
- R6: In the narrow layout, a write stores the low 32 bits of the write data, zero-extended. Bit 31 selects no translation (0) or the 32-bit scheme (1). Bits 30:22 give the identifier, zero-extended to 16 bits, and bits 21:0 give the page number. The 32-bit scheme applies no canonical check and requests with the low 32 bits of va.
- R7: In the wide layout, the identifier is bits 59:44 and the page number is bits 43:0. The root table base is the page number shifted left by 12.
- R8: A walk request carries the mxr and sum inputs unchanged.
- R9: A wide-layout write whose bits 63:60 hold any value other than 0, 8 or 9 leaves the control register unchanged. A legal write stores all 64 bits.
- R10: A fault carries cause 12 for a fetch (acc_type 0), 13 for a load (acc_type 1), and 15 for a store (2) or an atomic (3).
- R11: While acc_valid is high, exactly one of bypass, xlate_req and fault is high. While it is low, none is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_sv | input | 1 | Control register uses the 32-bit layout |
| csr_we | input | 1 | Write strobe for the control register |
| csr_wdata | input | 64 | Proposed control register value |
| csr_q | output | 64 | Current control register value |
| acc_valid | input | 1 | An access is presented |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 atomic |
| priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| mxr | input | 1 | Make-executable-readable flag |
| sum | input | 1 | Supervisor-user-access flag |
| va | input | 64 | Virtual address |
| bypass | output | 1 | Access is not translated |
| pa | output | 64 | Physical address on bypass |
| xlate_req | output | 1 | Walk request |
| req_mode | output | 2 | Scheme: 1 32-bit, 2 39-bit, 3 48-bit |
| req_va | output | 64 | Address handed to the walker |
| req_asid | output | 16 | Address-space identifier |
| req_root | output | 64 | Root page table base |
| req_mxr | output | 1 | Forwarded mxr |
| req_sum | output | 1 | Forwarded sum |
| fault | output | 1 | Immediate page fault |
| fault_cause | output | 6 | Exception cause code |

## Verification
The hardest case to reach is the interaction between the register's two layouts. A value written in the narrow layout has to discard its upper half, and the same stored bits then have to decode differently once the layout input changes. The stimulus writes a word with deliberate junk in bits 63:32 while the narrow layout is selected, checks the read-back and the Sv32 identifier and base, and then flips the layout input so that the same register is seen through the wide decode. Canonical edges are reached by placing single set bits just at and just above each scheme's sign bit.

// File: rtl/xlf_pkg.sv
// Shared types and constants for the translation front end.
// Assumes a 64-bit control register and 4 KiB base pages.
package xlf_pkg;
    typedef enum logic [1:0] {
        XM_BARE = 2'd0,
        XM_S32  = 2'd1,
        XM_S39  = 2'd2,
        XM_S48  = 2'd3
    } xmode_e;

    localparam logic [3:0] WIDE_BARE = 4'd0;
    localparam logic [3:0] WIDE_S39  = 4'd8;
    localparam logic [3:0] WIDE_S48  = 4'd9;

    localparam logic [5:0] CAUSE_IPF = 6'd12;
    localparam logic [5:0] CAUSE_LPF = 6'd13;
    localparam logic [5:0] CAUSE_SPF = 6'd15;

    localparam logic [1:0] PRIV_M = 2'd3;

    // Map access kind to page-fault cause code
    function automatic logic [5:0] cause_of(input logic [1:0] kind);
        case (kind)
            2'd0:    return CAUSE_IPF;
            2'd1:    return CAUSE_LPF;
            default: return CAUSE_SPF;
        endcase
    endfunction
endpackage

// File: rtl/xlf_ctl_reg.sv
// Control register with write legalization.
// Wide layout: a write whose mode nibble is unsupported is dropped.
// Narrow layout: the low word is kept, zero-extended.
module xlf_ctl_reg #(
    parameter int XW     = 64,
    parameter bit S48_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow_sv,
    input  logic          we,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] q
);
    import xlf_pkg::*;
    localparam int HALF = XW / 2;

    logic          legal;
    logic [XW-1:0] next_val;

    // Decide whether a wide-layout mode value is supported
    always_comb begin
        legal = (wdata[XW-1 -: 4] == WIDE_BARE) || (wdata[XW-1 -: 4] == WIDE_S39)
             || (S48_EN && (wdata[XW-1 -: 4] == WIDE_S48));
    end

    // Shape the value to be stored according to the layout
    always_comb begin
        if (narrow_sv) next_val = {{HALF{1'b0}}, wdata[HALF-1:0]};
        else           next_val = wdata;
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)                         q <= '0;
        else if (we && (narrow_sv || legal)) q <= next_val;
    end
endmodule

// File: rtl/xlf_mode_decode.sv
// Derives scheme, identifier and root base from privilege and register.
// Assumes machine privilege never translates.
module xlf_mode_decode #(
    parameter int XW     = 64,
    parameter int PG     = 12,
    parameter int ID_W   = 16,
    parameter int PN_W   = 44,
    parameter bit S48_EN = 1'b1
) (
    input  logic              narrow_sv,
    input  logic [1:0]        priv,
    input  logic [XW-1:0]     ctl,
    output xlf_pkg::xmode_e   mode,
    output logic [ID_W-1:0]   asid,
    output logic [XW-1:0]     root
);
    import xlf_pkg::*;
    localparam int N_ID = 9;
    localparam int N_PN = 22;

    logic [PN_W-1:0] pn;

    // Select the scheme from layout, mode field and privilege
    always_comb begin
        mode = XM_BARE;
        if (priv != PRIV_M) begin
            if (narrow_sv) begin
                mode = ctl[31] ? XM_S32 : XM_BARE;
            end else begin
                case (ctl[XW-1 -: 4])
                    WIDE_S39: mode = XM_S39;
                    WIDE_S48: mode = S48_EN ? XM_S48 : XM_BARE;
                    default:  mode = XM_BARE;
                endcase
            end
        end
    end

    // Extract identifier and page number for the active layout
    always_comb begin
        if (narrow_sv) begin
            asid = {{(ID_W-N_ID){1'b0}}, ctl[30:22]};
            pn   = {{(PN_W-N_PN){1'b0}}, ctl[N_PN-1:0]};
        end else begin
            asid = ctl[PN_W+ID_W-1:PN_W];
            pn   = ctl[PN_W-1:0];
        end
    end

    // Root table base is the page number scaled to page size
    always_comb begin
        root = {{(XW-PN_W-PG){1'b0}}, pn, {PG{1'b0}}};
    end
endmodule

// File: rtl/xlf_va_check.sv
// Canonical-address check per scheme; one checker per supported width.
// Assumes the 32-bit scheme needs no canonical check.
module xlf_va_check #(
    parameter int XW     = 64,
    parameter bit S48_EN = 1'b1
) (
    input  xlf_pkg::xmode_e mode,
    input  logic [XW-1:0]   va,
    output logic            va_ok
);
    import xlf_pkg::*;
    localparam int NW = 2;
    localparam int WIDTHS [NW] = '{39, 48};

    logic [NW-1:0] canon;

    for (genvar g = 0; g < NW; g++) begin : g_w
        localparam int W = WIDTHS[g];
        if (g == 0 || S48_EN) begin : g_on
            // Upper bits must all copy the sign bit
            always_comb begin
                canon[g] = (va[XW-1:W-1] == {(XW-W+1){1'b0}})
                        || (va[XW-1:W-1] == {(XW-W+1){1'b1}});
            end
        end else begin : g_off
            // Width not built
            always_comb canon[g] = 1'b0;
        end
    end

    // Pick the check that belongs to the scheme
    always_comb begin
        case (mode)
            XM_S39:  va_ok = canon[0];
            XM_S48:  va_ok = canon[1];
            default: va_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlate_front.sv
// Top of the translation front end: bypass, walk request or fault per access.
// Assumes priv is already the effective privilege of the access.
module xlate_front #(
    parameter int XW     = 64,
    parameter int PG     = 12,
    parameter int ID_W   = 16,
    parameter int PN_W   = 44,
    parameter bit S48_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            narrow_sv,
    input  logic            csr_we,
    input  logic [XW-1:0]   csr_wdata,
    output logic [XW-1:0]   csr_q,
    input  logic            acc_valid,
    input  logic [1:0]      acc_type,
    input  logic [1:0]      priv,
    input  logic            mxr,
    input  logic            sum,
    input  logic [XW-1:0]   va,
    output logic            bypass,
    output logic [XW-1:0]   pa,
    output logic            xlate_req,
    output logic [1:0]      req_mode,
    output logic [XW-1:0]   req_va,
    output logic [ID_W-1:0] req_asid,
    output logic [XW-1:0]   req_root,
    output logic            req_mxr,
    output logic            req_sum,
    output logic            fault,
    output logic [5:0]      fault_cause
);
    import xlf_pkg::*;
    localparam int HALF = XW / 2;

    xmode_e mode;
    logic   va_ok;

    xlf_ctl_reg #(.XW(XW), .S48_EN(S48_EN)) u_reg (
        .clk(clk), .rst_n(rst_n), .narrow_sv(narrow_sv),
        .we(csr_we), .wdata(csr_wdata), .q(csr_q)
    );

    xlf_mode_decode #(.XW(XW), .PG(PG), .ID_W(ID_W), .PN_W(PN_W), .S48_EN(S48_EN)) u_dec (
        .narrow_sv(narrow_sv), .priv(priv), .ctl(csr_q),
        .mode(mode), .asid(req_asid), .root(req_root)
    );

    xlf_va_check #(.XW(XW), .S48_EN(S48_EN)) u_chk (
        .mode(mode), .va(va), .va_ok(va_ok)
    );

    // Classify the access into exactly one outcome
    always_comb begin
        bypass    = acc_valid && (mode == XM_BARE);
        xlate_req = acc_valid && (mode != XM_BARE) && va_ok;
        fault     = acc_valid && (mode != XM_BARE) && !va_ok;
    end

    // Drive the addresses, the request fields and the cause code
    always_comb begin
        pa          = va;
        req_mode    = mode;
        req_va      = (mode == XM_S32) ? {{HALF{1'b0}}, va[HALF-1:0]} : va;
        req_mxr     = mxr;
        req_sum     = sum;
        fault_cause = fault ? cause_of(acc_type) : 6'd0;
    end
endmodule

// File: rtl/xlate_front_chk.sv
// Property checker for xlate_front, attached by bind below.
module xlate_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        narrow_sv,
    input logic        csr_we,
    input logic [63:0] csr_wdata,
    input logic [63:0] csr_q,
    input logic        acc_valid,
    input logic [1:0]  acc_type,
    input logic [1:0]  priv,
    input logic [63:0] va,
    input logic        bypass,
    input logic [63:0] pa,
    input logic        xlate_req,
    input logic [63:0] req_root,
    input logic        fault,
    input logic [5:0]  fault_cause
);
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({bypass, xlate_req, fault}));
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(bypass || xlate_req || fault));
    a_r2_machine_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && priv == 2'd3) |-> (bypass && pa == va));
    a_r9_drop_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !narrow_sv && csr_wdata[63:60] != 4'd0 && csr_wdata[63:60] != 4'd8
         && csr_wdata[63:60] != 4'd9) |=> $stable(csr_q));
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause == ((acc_type == 2'd0) ? 6'd12 :
                                   (acc_type == 2'd1) ? 6'd13 : 6'd15)));
    a_r7_root_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_req |-> (req_root[11:0] == 12'd0));
endmodule

bind xlate_front xlate_front_chk u_props (
    .clk(clk), .rst_n(rst_n), .narrow_sv(narrow_sv), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_q(csr_q), .acc_valid(acc_valid),
    .acc_type(acc_type), .priv(priv), .va(va), .bypass(bypass), .pa(pa),
    .xlate_req(xlate_req), .req_root(req_root), .fault(fault),
    .fault_cause(fault_cause)
);

// File: tb/sim_xlate_front.sv
module sim_xlate_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_sv = 1'b0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_q;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic [1:0]  priv = '0;
    logic        mxr = 1'b0;
    logic        sum = 1'b0;
    logic [63:0] va = '0;
    logic        bypass, xlate_req, fault, req_mxr, req_sum;
    logic [63:0] pa, req_va, req_root;
    logic [1:0]  req_mode;
    logic [15:0] req_asid;
    logic [5:0]  fault_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlate_front u0 (.*);

    // priv, type, va, outcome (0 bypass 1 request 2 fault), cause
    typedef struct packed {
        logic [1:0]  pv;
        logic [1:0]  ty;
        logic [63:0] a;
        logic [1:0]  oc;
        logic [5:0]  cs;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{2'd1, 2'd1, 64'h0000_003F_FFFF_F000, 2'd1, 6'd0},
        '{2'd1, 2'd1, 64'hFFFF_FFC0_0000_0000, 2'd1, 6'd0},
        '{2'd1, 2'd2, 64'h0000_0040_0000_0000, 2'd2, 6'd15},
        '{2'd0, 2'd0, 64'h8000_0000_0000_0000, 2'd2, 6'd12},
        '{2'd0, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 6'd13},
        '{2'd3, 2'd2, 64'h8000_0000_0000_0000, 2'd0, 6'd0},
        '{2'd0, 2'd0, 64'h0000_0000_0000_1000, 2'd1, 6'd0},
        '{2'd1, 2'd3, 64'h0000_8000_0000_0000, 2'd2, 6'd15}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic access(input logic [1:0] p, input logic [1:0] t, input logic [63:0] a);
        @(negedge clk);
        acc_valid = 1'b1; priv = p; acc_type = t; va = a;
        #1;
    endtask

    function automatic logic [1:0] outcome();
        return bypass ? 2'd0 : xlate_req ? 2'd1 : fault ? 2'd2 : 2'd3;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset value", csr_q, 64'd0);
        access(2'd0, 2'd1, 64'hFFFF_0000_1234_5678);
        check("R1 user bypass after reset", {62'd0, outcome()}, 64'd0);

        // Sv39 setup: mode 8, id ABCD, page number 12345
        wr({4'h8, 16'hABCD, 44'h0_0000_0012_345});
        check("R9 legal write stored", csr_q, {4'h8, 16'hABCD, 44'h0_0000_0012_345});
        for (int i = 0; i < NV; i++) begin
            access(VT[i].pv, VT[i].ty, VT[i].a);
            check("R3/R4/R10 outcome", {62'd0, outcome()}, {62'd0, VT[i].oc});
            check("R10 cause", {58'd0, fault_cause}, {58'd0, VT[i].cs});
            if (VT[i].oc == 2'd1) begin
                check("R7 asid", {48'd0, req_asid}, 64'hABCD);
                check("R7 root", req_root, 64'h1234_5000);
                check("R3 scheme 39", {62'd0, req_mode}, 64'd2);
            end
            if (VT[i].oc == 2'd0) check("R2 pa equals va", pa, VT[i].a);
        end

        // R8 flag forwarding
        mxr = 1'b1; sum = 1'b0;
        access(2'd1, 2'd1, 64'h1000);
        check("R8 mxr", {63'd0, req_mxr}, 64'd1);
        check("R8 sum", {63'd0, req_sum}, 64'd0);
        mxr = 1'b0; sum = 1'b1;
        #1;
        check("R8 sum high", {63'd0, req_sum}, 64'd1);

        // R11 idle
        @(negedge clk); acc_valid = 1'b0; #1;
        check("R11 idle", {61'd0, bypass, xlate_req, fault}, 64'd0);

        // R9 unsupported mode is dropped
        wr({4'h5, 60'h1});
        check("R9 bad mode kept old", csr_q, {4'h8, 16'hABCD, 44'h0_0000_0012_345});

        // R5 Sv48
        wr({4'h9, 16'h0001, 44'h7});
        access(2'd1, 2'd1, 64'h0000_4000_0000_0000);
        check("R5 bit46 request", {62'd0, outcome()}, 64'd1);
        check("R3 scheme 48", {62'd0, req_mode}, 64'd3);
        access(2'd1, 2'd1, 64'h0000_8000_0000_0000);
        check("R5 bit47 fault", {62'd0, outcome()}, 64'd2);
        access(2'd1, 2'd1, 64'hFFFF_8000_0000_0000);
        check("R5 sign-extended request", {62'd0, outcome()}, 64'd1);
        access(2'd3, 2'd0, 64'h0000_8000_0000_0000);
        check("R2 machine bypass under 48", {62'd0, outcome()}, 64'd0);

        // R3 mode 0 bypass for supervisor
        wr(64'h0000_0000_0000_0042);
        access(2'd1, 2'd2, 64'h8000_0000_0000_0000);
        check("R3 bare bypass", {62'd0, outcome()}, 64'd0);

        // R6 narrow layout
        @(negedge clk); acc_valid = 1'b0; narrow_sv = 1'b1;
        wr(64'hDEAD_BEEF_8123_4567);
        check("R6 narrow stored", csr_q, 64'h0000_0000_8123_4567);
        access(2'd1, 2'd1, 64'hFFFF_FFFF_8000_0000);
        check("R6 sv32 request", {62'd0, outcome()}, 64'd1);
        check("R6 scheme 32", {62'd0, req_mode}, 64'd1);
        check("R6 asid", {48'd0, req_asid}, 64'h0004);
        check("R6 root", req_root, 64'h2_3456_7000);
        check("R6 req va", req_va, 64'h8000_0000);
        wr(64'h0000_0000_7FFF_FFFF);
        access(2'd0, 2'd0, 64'h1234);
        check("R6 narrow bare", {62'd0, outcome()}, 64'd0);
        wr(64'h0000_0000_8000_0000);
        @(negedge clk); narrow_sv = 1'b0; #1;
        check("R3 wide view of stored word", {62'd0, outcome()}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule